// File: doc/BRIEF.md
# Oscillator Start-Up Timer with Request Gating

This block holds a device in a "clock not yet trusted" state after power-on reset or after leaving a low-power state. It counts input clock cycles until the oscillator can be treated as stable. At that point it raises a clock-ready status flag that software can poll. It also emits a one-cycle expiry pulse, so that a clock-output block can leave its reset-hold state.

While the count runs, three protected operations are held off:

- the transmit-start request,
- the receive-enable request,
- access to the protected MAC, MII and PHY register space.

Each of these arrives as a raw one-cycle strobe and leaves as a qualified strobe. A strobe raised too early is dropped, not queued, and a sticky error flag records that this happened. Ordinary register and buffer access goes straight through at all times.

Asserting power-down clears the ready flag and holds the count at zero. When power-down is released, the count starts again from the beginning. A software reset clears only the sticky error flag. It never restarts the timer.

Top module: `osc_start_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `clk_ready`, `expired_pulse` and `blocked_err` are 0.
- R2: `clk_ready` rises at the rising edge where `rst` and `pwr_down` have both been sampled low on START_CYCLES+1 consecutive edges, and not earlier. With the default START_CYCLES of 7500, this is 300 µs at 25 MHz plus one leaving-hold cycle.
- R3: Once high, `clk_ready` stays high until `rst` or `pwr_down` is sampled high.
- R4: When `pwr_down` is sampled high, `clk_ready` is 0 from the next cycle on. The count restarts from zero after release and again needs START_CYCLES+1 edges.
- R5: `expired_pulse` is high for exactly one cycle, the first cycle in which `clk_ready` is high.
- R6: `tx_start_ok`, `rx_enable_ok` and `prot_reg_ok` equal their request inputs while `clk_ready` is 1 and are 0 while it is 0.
- R7: `gen_acc_ok` equals `gen_acc_req` in every cycle, whatever the timer state.
- R8: A protected request sampled while `clk_ready` is 0 sets `blocked_err` from the next cycle. The flag then stays set until cleared by `rst` or `sw_rst`.
- R9: A `sw_rst` sampled high clears `blocked_err` on the next cycle, unless a blocked request arrives in the same cycle. `sw_rst` has no effect on `clk_ready` or on the count.
- R10: Protected requests made while `clk_ready` is 1 never set `blocked_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being timed |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pwr_down | input | 1 | Low-power state request, held high while powered down |
| sw_rst | input | 1 | Software reset strobe; clears the error flag only |
| tx_start_req | input | 1 | Raw transmit-start strobe |
| rx_enable_req | input | 1 | Raw receive-enable strobe |
| prot_reg_req | input | 1 | Raw protected-register access strobe |
| gen_acc_req | input | 1 | Ordinary register or buffer access strobe |
| clk_ready | output | 1 | Oscillator-stable status flag |
| tx_start_ok | output | 1 | Qualified transmit-start strobe |
| rx_enable_ok | output | 1 | Qualified receive-enable strobe |
| prot_reg_ok | output | 1 | Qualified protected-register access strobe |
| gen_acc_ok | output | 1 | Ordinary access strobe, never gated |
| expired_pulse | output | 1 | One-cycle pulse on timer expiry |
| blocked_err | output | 1 | Sticky flag: a protected request was dropped |

## Verification
The bench first aims at the exact expiry edge. A timer off by one cycle would raise the ready flag one cycle early or late, and the first gated strobe would leak or vanish with it.

It then asserts power-down in the middle of a count and again after expiry. A design that resumed the old count instead of restarting, or kept the flag through power-down, would show ready too soon after wake-up.

Next it sends software resets while the timer runs. A design that let software reset restart the timer would stretch the wait.

Finally it sends software resets in the same cycle as a blocked request. A design that gave the clear priority would lose that error.

// File: rtl/osc_tmr_pkg.sv
package osc_tmr_pkg;

    // Number of protected request kinds held off until the clock is ready
    localparam int PROT_NUM = 3;

    // Bit positions of the protected requests inside the request vector
    localparam int PRQ_TX   = 0;
    localparam int PRQ_RX   = 1;
    localparam int PRQ_PROT = 2;

    typedef enum logic [1:0] {
        OT_HOLD  = 2'd0,
        OT_COUNT = 2'd1,
        OT_READY = 2'd2
    } ot_state_e;

    typedef struct packed {
        ot_state_e state;
        logic      pulse;
    } ot_status_t;

    function automatic logic any_blocked(input logic [PROT_NUM-1:0] req,
                                         input logic ready);
        return (|req) & ~ready;
    endfunction

endpackage

// File: rtl/osc_tmr_count.sv
module osc_tmr_count
    import osc_tmr_pkg::*;
#(
    parameter int START_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    output logic ready,
    output logic expired_pulse
);

    localparam int              CNT_W = $clog2(START_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_CYCLES - 1);

    ot_status_t       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            st.state <= OT_HOLD;
            st.pulse <= 1'b0;
            cnt      <= '0;
        end else begin
            st.pulse <= 1'b0;
            unique case (st.state)
                OT_HOLD: begin
                    st.state <= OT_COUNT;
                    cnt      <= '0;
                end
                OT_COUNT: begin
                    if (cnt == LAST) begin
                        st.state <= OT_READY;
                        st.pulse <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                OT_READY: begin
                    st.state <= OT_READY;
                end
                default: begin
                    st.state <= OT_HOLD;
                    cnt      <= '0;
                end
            endcase
        end
    end

    assign ready         = (st.state == OT_READY);
    assign expired_pulse = st.pulse;

endmodule

// File: rtl/osc_tmr_gate.sv
module osc_tmr_gate
    import osc_tmr_pkg::*;
#(
    parameter int NREQ = PROT_NUM
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_rst,
    input  logic            ready,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] ok,
    output logic            blocked_err
);

    genvar g;
    generate
        for (g = 0; g < NREQ; g++) begin : g_qual
            assign ok[g] = req[g] & ready;
        end
    endgenerate

    logic blocked_now;
    assign blocked_now = any_blocked(req, ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked_err <= 1'b0;
        end else begin
            blocked_err <= (sw_rst ? 1'b0 : blocked_err) | blocked_now;
        end
    end

endmodule

// File: rtl/osc_start_timer.sv
module osc_start_timer
    import osc_tmr_pkg::*;
#(
    parameter int START_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic sw_rst,
    input  logic tx_start_req,
    input  logic rx_enable_req,
    input  logic prot_reg_req,
    input  logic gen_acc_req,
    output logic clk_ready,
    output logic tx_start_ok,
    output logic rx_enable_ok,
    output logic prot_reg_ok,
    output logic gen_acc_ok,
    output logic expired_pulse,
    output logic blocked_err
);

    logic [PROT_NUM-1:0] req_vec;
    logic [PROT_NUM-1:0] ok_vec;

    assign req_vec[PRQ_TX]   = tx_start_req;
    assign req_vec[PRQ_RX]   = rx_enable_req;
    assign req_vec[PRQ_PROT] = prot_reg_req;

    osc_tmr_count #(.START_CYCLES(START_CYCLES)) u_count (
        .clk          (clk),
        .rst          (rst),
        .pwr_down     (pwr_down),
        .ready        (clk_ready),
        .expired_pulse(expired_pulse)
    );

    osc_tmr_gate #(.NREQ(PROT_NUM)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .sw_rst     (sw_rst),
        .ready      (clk_ready),
        .req        (req_vec),
        .ok         (ok_vec),
        .blocked_err(blocked_err)
    );

    assign tx_start_ok  = ok_vec[PRQ_TX];
    assign rx_enable_ok = ok_vec[PRQ_RX];
    assign prot_reg_ok  = ok_vec[PRQ_PROT];

    // Ordinary register and buffer access is never gated
    assign gen_acc_ok = gen_acc_req;

endmodule

// File: rtl/osc_start_timer_chk.sv
module osc_start_timer_chk #(
    parameter int START_CYCLES = 7500
) (
    input logic clk,
    input logic rst,
    input logic pwr_down,
    input logic sw_rst,
    input logic tx_start_req,
    input logic rx_enable_req,
    input logic prot_reg_req,
    input logic clk_ready,
    input logic tx_start_ok,
    input logic rx_enable_ok,
    input logic prot_reg_ok,
    input logic expired_pulse,
    input logic blocked_err
);

    localparam int RUN_W = $clog2(START_CYCLES + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(START_CYCLES + 1);

    // Edges with both rst and pwr_down low, saturating
    logic [RUN_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst || pwr_down) run_cnt <= '0;
        else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
    end

    a_r2_min_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_ready) |-> (run_cnt == RUN_MAX));

    a_r3_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (clk_ready && !pwr_down) |=> clk_ready);

    a_r4_pd_clears: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !clk_ready);

    a_r5_pulse_first: assert property (@(posedge clk) disable iff (rst)
        expired_pulse |-> (clk_ready && $rose(clk_ready)));

    a_r5_pulse_once: assert property (@(posedge clk) disable iff (rst)
        expired_pulse |=> !expired_pulse);

    a_r6_gated: assert property (@(posedge clk) disable iff (rst)
        (tx_start_ok || rx_enable_ok || prot_reg_ok) |-> clk_ready);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (blocked_err && !sw_rst) |=> blocked_err);

    a_r8_sets: assert property (@(posedge clk) disable iff (rst)
        ((tx_start_req || rx_enable_req || prot_reg_req) && !clk_ready) |=> blocked_err);

endmodule

bind osc_start_timer osc_start_timer_chk #(.START_CYCLES(START_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_down     (pwr_down),
    .sw_rst       (sw_rst),
    .tx_start_req (tx_start_req),
    .rx_enable_req(rx_enable_req),
    .prot_reg_req (prot_reg_req),
    .clk_ready    (clk_ready),
    .tx_start_ok  (tx_start_ok),
    .rx_enable_ok (rx_enable_ok),
    .prot_reg_ok  (prot_reg_ok),
    .expired_pulse(expired_pulse),
    .blocked_err  (blocked_err)
);

// File: tb/tb_osc_start_timer.sv
`timescale 1ns/1ps
module tb_osc_start_timer;

    localparam int N = 50;

    logic clk = 1'b0;
    logic rst = 1'b1, pwr_down = 1'b0, sw_rst = 1'b0;
    logic tx = 1'b0, rx = 1'b0, pr = 1'b0, ga = 1'b0;
    logic clk_ready, tx_ok, rx_ok, pr_ok, ga_ok, pulse, err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model state
    int since = 0;
    bit m_err = 1'b0;

    always #4 clk = ~clk;

    osc_start_timer #(.START_CYCLES(N)) dut (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .sw_rst(sw_rst),
        .tx_start_req(tx), .rx_enable_req(rx), .prot_reg_req(pr),
        .gen_acc_req(ga), .clk_ready(clk_ready), .tx_start_ok(tx_ok),
        .rx_enable_ok(rx_ok), .prot_reg_ok(pr_ok), .gen_acc_ok(ga_ok),
        .expired_pulse(pulse), .blocked_err(err)
    );

    function automatic bit exp_ready(input int s);
        return s >= N + 1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)",
                     req, what, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, step the model at the rising edge, check after
    task automatic step(input bit r, input bit pd, input bit sw,
                        input bit t, input bit x, input bit p, input bit g);
        bit rdy_before;
        @(negedge clk);
        rst = r; pwr_down = pd; sw_rst = sw; tx = t; rx = x; pr = p; ga = g;
        rdy_before = exp_ready(since);
        @(posedge clk);
        if (r) m_err = 1'b0;
        else   m_err = (sw ? 1'b0 : m_err) | ((t | x | p) & ~rdy_before);
        if (r || pd) since = 0;
        else if (since < N + 1) since++;
        #1;
        check("R2", "clk_ready", clk_ready, exp_ready(since));
        check("R5", "expired_pulse", pulse, since == N + 1 && rdy_before == 1'b0);
        check("R6", "tx_start_ok", tx_ok, t & exp_ready(since));
        check("R6", "rx_enable_ok", rx_ok, x & exp_ready(since));
        check("R6", "prot_reg_ok", pr_ok, p & exp_ready(since));
        check("R7", "gen_acc_ok", ga_ok, g);
        check("R8", "blocked_err", err, m_err);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 1, 1, 1);
        // R1: reset state
        check("R1", "ready in reset", clk_ready, 1'b0);
        check("R1", "pulse in reset", pulse, 1'b0);
        check("R1", "err in reset", err, 1'b0);

        // R2 exact expiry edge, with sw_rst strobes mid-count (R9: no restart)
        for (int i = 0; i < N + 1; i++) begin
            step(0, 0, (i == 10 || i == 30), 0, 0, 0, 0);
            if (i == N - 1) check("R2", "not ready one edge early", clk_ready, 1'b0);
        end
        check("R9", "sw_rst did not delay ready", clk_ready, 1'b1);
        idle(3);
        check("R3", "ready holds", clk_ready, 1'b1);

        // R10: requests while ready leave err clear
        step(0, 0, 0, 1, 1, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        check("R10", "no err when ready", err, 1'b0);

        // R4: power-down clears ready, wake restarts full count
        step(0, 1, 0, 0, 0, 0, 0);
        check("R4", "ready cleared by pwr_down", clk_ready, 1'b0);
        step(0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) step(0, 0, 0, 0, 0, 0, 0);
        check("R4", "not ready before full recount", clk_ready, 1'b0);
        step(0, 0, 0, 0, 0, 0, 0);
        check("R4", "ready after full recount", clk_ready, 1'b1);

        // R4: power-down mid-count restarts from zero
        step(0, 1, 0, 0, 0, 0, 0);
        idle(N / 2);
        step(0, 1, 0, 0, 0, 0, 0);
        idle(N);
        check("R4", "mid-count restart", clk_ready, 1'b0);
        idle(1);
        check("R4", "mid-count restart expiry", clk_ready, 1'b1);

        // R8/R9: blocked request and sw_rst in the same cycle keeps err set
        step(0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0, 0);
        check("R9", "set beats clear", err, 1'b1);
        step(0, 0, 1, 0, 0, 0, 0);
        check("R9", "sw_rst clears err", err, 1'b0);
        step(0, 0, 0, 0, 0, 1, 1);
        idle(4);
        check("R8", "err sticky", err, 1'b1);

        // Constrained random phase
        for (int i = 0; i < 12000; i++) begin
            bit r, pd, sw;
            r  = ($urandom % 2000) == 0;
            pd = ($urandom % 150) == 0 ? 1'b1 : (pwr_down && ($urandom % 4) != 0);
            sw = ($urandom % 40) == 0;
            step(r, pd, sw, ($urandom % 23) == 0, ($urandom % 29) == 0,
                 ($urandom % 19) == 0, $urandom % 2);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule